// File: doc/BRIEF.md
# Split TLB Translation and Permission Checker

This block turns a virtual address into a physical address. It has two direct-mapped translation tables, one for instruction fetches and one for data accesses. Both tables are indexed with the same bits of the address, and one access reads both at once. The permissions the two entries hold are merged into one set of read, write and execute rights for the current privilege level.

When the two indexed entries point at different physical pages, the entry the access does not need is ignored. A failed access is reported in one of two ways. It is a protection fault when a valid matching entry exists but lacks the right, and a table miss when no such entry exists. Each is reported in an instruction form and a data form.

A write port loads entries into either table. An enable input turns translation off, so that addresses pass through unchanged with full rights. A request is captured on the clock edge, and its result is presented during the following cycle.

Top module: `split_tlb_xlate`

## Requirements
- R1: The entry index is virtual address bits [18:13] (six bits above the 13-bit page offset). The same index selects the instruction-table entry and the data-table entry.
- R2: If the physical page fields (bits [31:13]) of the two indexed translate words differ, one entry is treated as all zeros. A fetch drops the data entry. A load or store drops the instruction entry.
- R3: An entry matches when its match-word bits [31:13] equal the address bits [31:13]. Match-word bit 0 is its valid bit. The valid set is execute from a valid matching instruction entry, plus read and write from a valid matching data entry.
- R4: Translate-word permission bits are: bit 0 user read, bit 1 user write, bit 2 user execute, bit 3 supervisor read, bit 4 supervisor write, bit 5 supervisor execute. Execute comes from the instruction entry, and read and write come from the data entry. The supervisor flag picks the supervisor bits, otherwise the user bits are used.
- R5: rsp_perm_o (bit 0 read, bit 1 write, bit 2 execute) is the selected permissions ANDed with the valid set.
- R6: rsp_paddr_o is the OR of the two translate-word page fields, followed by the address bits [12:0].
- R7: Access kind 0 (fetch) needs execute, kind 1 (load) needs read, and kind 2 (store) needs write. The status is 0 (OK) when the needed right is in rsp_perm_o.
- R8: A failed access returns a fault when the needed right is in the valid set, and a miss otherwise. The codes are 1 for an instruction fault, 2 for a data fault, 3 for an instruction miss and 4 for a data miss. The instruction codes apply to a fetch and the data codes to a load or store.
- R9: With mmu_en_i low at capture, rsp_paddr_o equals the virtual address, rsp_perm_o is 3'b111 and the status is OK, whatever the tables hold.
- R10: rsp_valid_o is high in exactly the cycle after a cycle with req_valid_i high, and is 0 after reset. Tables reset to zero. An entry written at one edge is used by a request captured at any later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Capture a request on this edge |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | 0 fetch, 1 load, 2 store |
| req_super_i | input | 1 | Supervisor privilege |
| mmu_en_i | input | 1 | Translation enabled |
| wr_en_i | input | 1 | Write a table entry |
| wr_dtlb_i | input | 1 | 1 selects the data table, 0 the instruction table |
| wr_idx_i | input | 6 | Entry index to write |
| wr_match_i | input | 32 | Match word: page tag [31:13], valid bit [0] |
| wr_xlate_i | input | 32 | Translate word: physical page [31:13], permissions [5:0] |
| rsp_valid_o | output | 1 | Result valid |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_perm_o | output | 3 | Granted rights: bit 0 read, bit 1 write, bit 2 execute |
| rsp_status_o | output | 3 | 0 OK, 1 instruction fault, 2 data fault, 3 instruction miss, 4 data miss |

## Verification
Directed accesses check the shared index: entries at a neighbouring index must not be used. They also check write-to-use latency and the response timing. A long pseudo-random sweep loads entry pairs with every mix of tag match, valid bit, shared or distinct physical page, and permission bits. It also puts junk in the unused bit fields. Each pair is then accessed with all three kinds at both privilege levels. This separates a fault from a miss, the instruction codes from the data codes, and a discarded entry from a kept one. A bypass sweep with translation disabled, over populated tables, checks that the address passes through unchanged.

// File: rtl/split_tlb_pkg.sv
package split_tlb_pkg;
  parameter int ADDR_W    = 32;
  parameter int PAGE_BITS = 13;
  parameter int IDX_W     = 6;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_OK    = 3'd0,
    ST_IFLT  = 3'd1,
    ST_DFLT  = 3'd2,
    ST_IMISS = 3'd3,
    ST_DMISS = 3'd4
  } xl_status_e;

  // granted-rights vector positions
  localparam int RT_R = 0;
  localparam int RT_W = 1;
  localparam int RT_X = 2;

  // translate-word permission positions
  localparam int TW_UR = 0;
  localparam int TW_UW = 1;
  localparam int TW_UX = 2;
  localparam int TW_SR = 3;
  localparam int TW_SW = 4;
  localparam int TW_SX = 5;
  localparam int TW_PERM_W = 6;
endpackage

// File: rtl/tlb_bank.sv
module tlb_bank #(
  parameter int ADDR_W = split_tlb_pkg::ADDR_W,
  parameter int IDX_W  = split_tlb_pkg::IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_match_i,
  input  logic [ADDR_W-1:0] wr_xlate_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_match_o,
  output logic [ADDR_W-1:0] rd_xlate_o
);
  localparam int N_ENT = 1 << IDX_W;

  logic [ADDR_W-1:0] match_q [N_ENT];
  logic [ADDR_W-1:0] xlate_q [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_ENT; e++) begin
        match_q[e] <= '0;
        xlate_q[e] <= '0;
      end
    end else if (wr_en_i) begin
      match_q[wr_idx_i] <= wr_match_i;
      xlate_q[wr_idx_i] <= wr_xlate_i;
    end
  end

  assign rd_match_o = match_q[rd_idx_i];
  assign rd_xlate_o = xlate_q[rd_idx_i];

  AST_WR_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_idx_i == wr_idx_i) |=>
      (rd_idx_i != $past(wr_idx_i)) ||
      (rd_match_o == $past(wr_match_i) && rd_xlate_o == $past(wr_xlate_i))); // R10
endmodule

// File: rtl/tlb_req_stage.sv
module tlb_req_stage #(
  parameter int ADDR_W = split_tlb_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_super_i,
  input  logic              mmu_en_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] vaddr_o,
  output logic [1:0]        kind_o,
  output logic              super_o,
  output logic              mmu_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      vaddr_o  <= '0;
      kind_o   <= '0;
      super_o  <= 1'b0;
      mmu_en_o <= 1'b0;
    end else begin
      valid_o <= req_valid_i;
      if (req_valid_i) begin
        vaddr_o  <= req_vaddr_i;
        kind_o   <= req_kind_i;
        super_o  <= req_super_i;
        mmu_en_o <= mmu_en_i;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_core.sv
module tlb_lookup_core
  import split_tlb_pkg::*;
#(
  parameter int ADDR_W    = split_tlb_pkg::ADDR_W,
  parameter int PAGE_BITS = split_tlb_pkg::PAGE_BITS,
  parameter int IDX_W     = split_tlb_pkg::IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [1:0]        kind_i,
  input  logic              super_i,
  input  logic              mmu_en_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [ADDR_W-1:0] imr_i,
  input  logic [ADDR_W-1:0] itr_i,
  input  logic [ADDR_W-1:0] dmr_i,
  input  logic [ADDR_W-1:0] dtr_i,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [2:0]        perm_o,
  output logic [2:0]        status_o
);
  localparam int VPN_W = ADDR_W - PAGE_BITS;

  logic [VPN_W-1:0] va_vpn;
  logic [ADDR_W-1:0] imr, itr, dmr, dtr;
  logic [2:0] need, match_set, valid_set, sel_rt, granted;
  logic [VPN_W-1:0] phys_vpn;
  logic is_fetch;
  xl_status_e st;

  assign va_vpn   = vaddr_i[ADDR_W-1:PAGE_BITS];
  assign rd_idx_o = vaddr_i[PAGE_BITS +: IDX_W];
  assign is_fetch = (kind_i == ACC_FETCH);

  always_comb begin
    imr = imr_i;
    itr = itr_i;
    dmr = dmr_i;
    dtr = dtr_i;
    // drop the entry the access does not need when the pages disagree
    if (itr_i[ADDR_W-1:PAGE_BITS] != dtr_i[ADDR_W-1:PAGE_BITS]) begin
      if (is_fetch) begin
        dmr = '0;
        dtr = '0;
      end else begin
        imr = '0;
        itr = '0;
      end
    end

    need = '0;
    unique case (kind_i)
      ACC_FETCH: need[RT_X] = 1'b1;
      ACC_STORE: need[RT_W] = 1'b1;
      default:   need[RT_R] = 1'b1;
    endcase

    match_set[RT_X] = (imr[ADDR_W-1:PAGE_BITS] == va_vpn);
    match_set[RT_R] = (dmr[ADDR_W-1:PAGE_BITS] == va_vpn);
    match_set[RT_W] = match_set[RT_R];

    valid_set[RT_X] = imr[0] & match_set[RT_X];
    valid_set[RT_R] = dmr[0] & match_set[RT_R];
    valid_set[RT_W] = dmr[0] & match_set[RT_W];

    sel_rt[RT_X] = super_i ? itr[TW_SX] : itr[TW_UX];
    sel_rt[RT_R] = super_i ? dtr[TW_SR] : dtr[TW_UR];
    sel_rt[RT_W] = super_i ? dtr[TW_SW] : dtr[TW_UW];

    granted  = sel_rt & valid_set;
    phys_vpn = itr[ADDR_W-1:PAGE_BITS] | dtr[ADDR_W-1:PAGE_BITS];

    if ((need & granted) != 3'b000) st = ST_OK;
    else if ((need & valid_set) != 3'b000) st = is_fetch ? ST_IFLT : ST_DFLT;
    else st = is_fetch ? ST_IMISS : ST_DMISS;
  end

  always_comb begin
    if (mmu_en_i) begin
      paddr_o  = {phys_vpn, vaddr_i[PAGE_BITS-1:0]};
      perm_o   = granted;
      status_o = st;
    end else begin
      paddr_o  = vaddr_i;
      perm_o   = 3'b111;
      status_o = ST_OK;
    end
  end

  logic unused_fields;
  assign unused_fields = ^{imr[PAGE_BITS-1:1], dmr[PAGE_BITS-1:1],
                           itr[PAGE_BITS-1:TW_PERM_W], dtr[PAGE_BITS-1:TW_PERM_W],
                           itr[TW_SW:TW_SR], itr[TW_UW:TW_UR],
                           dtr[TW_SX], dtr[TW_UX]};

  AST_OK_HAS_NEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && mmu_en_i && status_o == ST_OK) |-> ((perm_o & need) != 3'b000)); // R7
  AST_FETCH_FAIL_INSTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && mmu_en_i && is_fetch && status_o != ST_OK) |->
      (status_o == ST_IFLT || status_o == ST_IMISS)); // R8
  AST_DATA_FAIL_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && mmu_en_i && !is_fetch && status_o != ST_OK) |->
      (status_o == ST_DFLT || status_o == ST_DMISS)); // R8
  AST_EXEC_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && mmu_en_i && perm_o[RT_X]) |->
      (imr_i[0] && imr_i[ADDR_W-1:PAGE_BITS] == va_vpn)); // R3
  AST_READ_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && mmu_en_i && perm_o[RT_R]) |->
      (dmr_i[0] && dmr_i[ADDR_W-1:PAGE_BITS] == va_vpn)); // R3
endmodule

// File: rtl/split_tlb_xlate.sv
module split_tlb_xlate
  import split_tlb_pkg::*;
#(
  parameter int ADDR_W    = split_tlb_pkg::ADDR_W,
  parameter int PAGE_BITS = split_tlb_pkg::PAGE_BITS,
  parameter int IDX_W     = split_tlb_pkg::IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_super_i,
  input  logic              mmu_en_i,
  input  logic              wr_en_i,
  input  logic              wr_dtlb_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_match_i,
  input  logic [ADDR_W-1:0] wr_xlate_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic [2:0]        rsp_perm_o,
  output logic [2:0]        rsp_status_o
);
  localparam int N_BANK = 2;

  logic              q_valid, q_super, q_mmu_en;
  logic [ADDR_W-1:0] q_vaddr;
  logic [1:0]        q_kind;
  logic [IDX_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] bank_match [N_BANK];
  logic [ADDR_W-1:0] bank_xlate [N_BANK];

  tlb_req_stage #(.ADDR_W(ADDR_W)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_vaddr_i (req_vaddr_i),
    .req_kind_i  (req_kind_i),
    .req_super_i (req_super_i),
    .mmu_en_i    (mmu_en_i),
    .valid_o     (q_valid),
    .vaddr_o     (q_vaddr),
    .kind_o      (q_kind),
    .super_o     (q_super),
    .mmu_en_o    (q_mmu_en)
  );

  // bank 0: instruction table, bank 1: data table
  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    localparam logic BANK_SEL = (b == 1) ? 1'b1 : 1'b0;
    tlb_bank #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i && (wr_dtlb_i == BANK_SEL)),
      .wr_idx_i   (wr_idx_i),
      .wr_match_i (wr_match_i),
      .wr_xlate_i (wr_xlate_i),
      .rd_idx_i   (rd_idx),
      .rd_match_o (bank_match[b]),
      .rd_xlate_o (bank_xlate[b])
    );
  end

  tlb_lookup_core #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (q_valid),
    .vaddr_i  (q_vaddr),
    .kind_i   (q_kind),
    .super_i  (q_super),
    .mmu_en_i (q_mmu_en),
    .rd_idx_o (rd_idx),
    .imr_i    (bank_match[0]),
    .itr_i    (bank_xlate[0]),
    .dmr_i    (bank_match[1]),
    .dtr_i    (bank_xlate[1]),
    .paddr_o  (rsp_paddr_o),
    .perm_o   (rsp_perm_o),
    .status_o (rsp_status_o)
  );

  assign rsp_valid_o = q_valid;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R10
  AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R10
  AST_BYPASS_IDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !mmu_en_i) |=>
      (rsp_paddr_o == $past(req_vaddr_i) && rsp_perm_o == 3'b111 &&
       rsp_status_o == ST_OK)); // R9
endmodule

// File: tb/tb_split_tlb_xlate.sv
module tb_split_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_super = 1'b0;
  logic        mmu_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_dtlb = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_match = '0;
  logic [31:0] wr_xlate = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic [2:0]  rsp_status;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [31:0] mi [64];
  logic [31:0] ti [64];
  logic [31:0] md [64];
  logic [31:0] td [64];

  split_tlb_xlate dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_kind_i(req_kind), .req_super_i(req_super), .mmu_en_i(mmu_en),
    .wr_en_i(wr_en), .wr_dtlb_i(wr_dtlb), .wr_idx_i(wr_idx), .wr_match_i(wr_match),
    .wr_xlate_i(wr_xlate), .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
    .rsp_perm_o(rsp_perm), .rsp_status_o(rsp_status)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]};
  endfunction

  // expected result computed from the requirements
  task automatic model(input logic [31:0] va, input logic [1:0] k, input logic s,
                       input logic en, output logic [31:0] pa, output logic [2:0] pm,
                       output logic [2:0] st);
    logic [5:0] ix;
    logic [31:0] im, it, dm, dt;
    logic [2:0] need, vs, sel;
    if (!en) begin
      pa = va; pm = 3'b111; st = 3'd0;
      return;
    end
    ix = va[18:13];
    im = mi[ix]; it = ti[ix]; dm = md[ix]; dt = td[ix];
    if (it[31:13] != dt[31:13]) begin
      if (k == 2'd0) begin dm = 0; dt = 0; end
      else begin im = 0; it = 0; end
    end
    need = (k == 2'd0) ? 3'b100 : (k == 2'd2) ? 3'b010 : 3'b001;
    vs[2] = im[0] && (im[31:13] == va[31:13]);
    vs[1] = dm[0] && (dm[31:13] == va[31:13]);
    vs[0] = vs[1];
    sel = s ? {it[5], dt[4], dt[3]} : {it[2], dt[1], dt[0]};
    pm = sel & vs;
    pa = {it[31:13] | dt[31:13], va[12:0]};
    if ((need & pm) != 0) st = 3'd0;
    else if ((need & vs) != 0) st = (k == 2'd0) ? 3'd1 : 3'd2;
    else st = (k == 2'd0) ? 3'd3 : 3'd4;
  endtask

  task automatic wr_entry(input logic d, input logic [5:0] ix, input logic [31:0] m,
                          input logic [31:0] t);
    @(negedge clk);
    wr_en = 1'b1; wr_dtlb = d; wr_idx = ix; wr_match = m; wr_xlate = t;
    @(negedge clk);
    wr_en = 1'b0;
    if (d) begin md[ix] = m; td[ix] = t; end
    else begin mi[ix] = m; ti[ix] = t; end
  endtask

  task automatic do_req(input logic [31:0] va, input logic [1:0] k, input logic s,
                        input logic en, input string tag);
    logic [31:0] pa;
    logic [2:0] pm, st;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = k; req_super = s; mmu_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    model(va, k, s, en, pa, pm, st);
    chk({tag, " valid R10"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " paddr R6"}, rsp_paddr, pa);
    chk({tag, " perm R5"}, {29'd0, rsp_perm}, {29'd0, pm});
    chk({tag, " status R8"}, {29'd0, rsp_status}, {29'd0, st});
  endtask

  initial begin
    for (int e = 0; e < 64; e++) begin
      mi[e] = 0; ti[e] = 0; md[e] = 0; td[e] = 0;
    end
    #1;
    chk("reset valid R10", {31'd0, rsp_valid}, 32'd0);
    #20;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("idle valid R10", {31'd0, rsp_valid}, 32'd0);

    // empty tables: misses
    do_req(32'h0000_2000, 2'd0, 1'b1, 1'b1, "empty fetch R8");
    do_req(32'h0000_2000, 2'd1, 1'b0, 1'b1, "empty load R8");

    // index: entries at idx 5 serve a page whose index is 5, idx 6 stays empty
    wr_entry(1'b0, 6'd5, {19'h40005, 12'd0, 1'b1}, {19'h12345, 7'd0, 6'h3f});
    wr_entry(1'b1, 6'd5, {19'h40005, 12'd0, 1'b1}, {19'h12345, 7'd0, 6'h3f});
    do_req({19'h40005, 13'h0abc}, 2'd0, 1'b0, 1'b1, "index hit R1");
    chk("index hit status R7", {29'd0, rsp_status}, 32'd0);
    chk("index hit paddr R1", rsp_paddr, {19'h12345, 13'h0abc});
    do_req({19'h40006, 13'h0abc}, 2'd2, 1'b0, 1'b1, "index neighbour R1");
    chk("index neighbour miss R1", {29'd0, rsp_status}, 32'd4);
    @(negedge clk);
    chk("valid drops R10", {31'd0, rsp_valid}, 32'd0);

    // supervisor-only rights: user fault, supervisor ok
    wr_entry(1'b1, 6'd5, {19'h40005, 12'd0, 1'b1}, {19'h12345, 7'd0, 6'h38});
    do_req({19'h40005, 13'h0}, 2'd1, 1'b0, 1'b1, "user load R4");
    chk("user load fault R4", {29'd0, rsp_status}, 32'd2);
    do_req({19'h40005, 13'h0}, 2'd1, 1'b1, 1'b1, "super load R4");
    chk("super load ok R4", {29'd0, rsp_status}, 32'd0);

    // distinct pages: fetch keeps the instruction entry only
    wr_entry(1'b1, 6'd5, {19'h40005, 12'd0, 1'b1}, {19'h00777, 7'd0, 6'h3f});
    do_req({19'h40005, 13'h1}, 2'd0, 1'b1, 1'b1, "split fetch R2");
    chk("split fetch paddr R2", rsp_paddr, {19'h12345, 13'h1});
    do_req({19'h40005, 13'h1}, 2'd2, 1'b1, 1'b1, "split store R2");
    chk("split store paddr R2", rsp_paddr, {19'h00777, 13'h1});

    // randomized sweep
    for (int n = 0; n < 500; n++) begin
      logic [31:0] va, r;
      logic [5:0] ix;
      logic [18:0] ippn, dppn, itag, dtag;
      va = rnd();
      ix = va[18:13];
      r = rnd();
      itag = r[0] ? va[31:13] : va[31:13] ^ (19'd1 << (r[8:4] % 19));
      dtag = r[1] ? va[31:13] : va[31:13] ^ (19'd1 << (r[13:9] % 19));
      ippn = rnd();
      dppn = r[2] ? ippn : 19'(rnd());
      wr_entry(1'b0, ix, {itag, 12'(rnd()), r[3]}, {ippn, 7'(rnd()), r[19:14]});
      wr_entry(1'b1, ix, {dtag, 12'(rnd()), r[20]}, {dppn, 7'(rnd()), r[26:21]});
      for (int k = 0; k < 3; k++) begin
        for (int s = 0; s < 2; s++) begin
          do_req(va, 2'(k), 1'(s), 1'b1, "sweep R2 R3 R4 R7");
        end
      end
    end

    // bypass over populated tables
    for (int n = 0; n < 60; n++) begin
      logic [31:0] va;
      va = rnd();
      do_req(va, 2'(n % 3), 1'(n % 2), 1'b0, "bypass R9");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule